// File: doc/BRIEF.md
# Operand Address Resolver

This block turns one decoded operand specifier of a 32-bit processor into either an operand value or a memory address. The specifier gives an addressing mode, a base register number, an index register (bank, number and whether it is taken at word or long size), a displacement or absolute/literal value, and an operand size. The block reads the base and index registers through two combinational register-file read selects, adds the terms, and presents the result one clock after the request. For the stepping modes it also issues a write-back of the adjusted base register.

Two request kinds exist. A value request resolves any mode: literals and register contents come back as values, and every memory mode comes back as an address. A control request asks for a target address for jumps and address loads. It accepts only the modes that name a memory location without side effects; every other mode returns an error.

Top module: `ea_unit`

## Requirements
- R1: `rspValid` is high exactly one cycle after a cycle with `reqValid` high. While reset is asserted every output register reads zero.
- R2: Mode 0 (literal) returns `disp` unchanged as a value (`rspIsAddr`=0), with no write-back.
- R3: Mode 1 (data register) and mode 2 (address register) return the register limited to the operand size. Size code 0 gives the low 8 bits, 1 the low 16 bits, 2 and 3 all 32 bits. `rfBaseSel` is {bank, number}, where bank 0 is the data bank and bank 1 the address bank.
- R4: Mode 3 (register indirect) returns the address register's value as an address.
- R5: Mode 4 (post-step) returns the unmodified base as the address. It writes back base+1, +2 or +4 for size codes 0, 1 and 2/3 to `wbReg`.
- R6: Mode 5 (pre-step) returns base minus 1, 2 or 4 as the address, and writes back the same value.
- R7: Mode 6 adds the low 16 bits of `disp`, sign-extended, to the base. The sum wraps modulo 2^32.
- R8: Mode 7 adds base, index and sign-extended 16-bit displacement. `rfIdxSel` is {`idxIsAddr`, `idxReg`}. When `idxLong`=0 the index's low 16 bits are sign-extended; when `idxLong`=1 the full 32 bits are used.
- R9: Mode 8 (absolute) returns all 32 bits of `disp` as the address.
- R10: Mode 9 is `pc` plus the sign-extended 16-bit displacement. Mode 10 additionally adds the index as in R8.
- R11: With `reqCtrl`=1, modes 3, 6, 7, 8, 9 and 10 return the address with no write-back. Modes 0, 1, 2, 4 and 5 raise `rspErr`, with `rspData`=0, `rspIsAddr`=0 and no write-back.
- R12: Mode codes 11 to 15 raise `rspErr` for either request kind, with `rspData`=0 and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqCtrl | input | 1 | 1 = control-address request, 0 = value request |
| mode | input | 4 | Addressing mode code |
| baseReg | input | 3 | Base register number |
| idxIsAddr | input | 1 | Index bank: 1 = address bank |
| idxReg | input | 3 | Index register number |
| idxLong | input | 1 | Index taken at 32 bits when 1, 16 bits when 0 |
| disp | input | 32 | Displacement, absolute address or literal |
| opSize | input | 2 | Operand size code |
| pc | input | 32 | Current program counter |
| rfBaseSel | output | 4 | Base read select {bank, number} |
| rfBaseData | input | 32 | Base register value |
| rfIdxSel | output | 4 | Index read select {bank, number} |
| rfIdxData | input | 32 | Index register value |
| rspValid | output | 1 | Result valid |
| rspIsAddr | output | 1 | Result is a memory address |
| rspErr | output | 1 | Illegal mode for the request kind |
| rspData | output | 32 | Value or address |
| wbValid | output | 1 | Base register write-back strobe |
| wbReg | output | 3 | Address register to write back |
| wbData | output | 32 | Write-back value |

## Verification
The bench aims at the step direction and timing. A post-step that used the adjusted value, or a pre-step that returned the old base, shows up as an address off by the step. Index handling is checked with a negative word index, where a missing sign extension adds 0xFFFE instead of subtracting 2. The same index is also read at long size, and the bank is chosen so that reading the wrong bank gives a different sum. Displacement wrap-around past 2^32 and ignored upper displacement bits are covered. So are control requests on side-effecting modes, which must error with no write-back rather than step a register.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_LIT     = 4'd0,
    M_DREG    = 4'd1,
    M_AREG    = 4'd2,
    M_IND     = 4'd3,
    M_POSTSTEP = 4'd4,
    M_PRESTEP = 4'd5,
    M_DISP    = 4'd6,
    M_IDX     = 4'd7,
    M_ABS     = 4'd8,
    M_PCDISP  = 4'd9,
    M_PCIDX   = 4'd10
  } eaMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bankAddr;  // base read from address bank
    logic selBase;   // base term is the register
    logic selPc;     // base term is the pc
    logic addDisp;   // add sign-extended short displacement
    logic dispFull;  // add the full 32-bit value
    logic addIdx;    // add index term
    logic useLit;    // result is the literal
    logic sizeMask;  // result is register limited to size
    logic postStep;
    logic preStep;
    logic isAddr;
    logic err;
  } eaStrobe_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  input  logic       reqCtrl,
  output eaStrobe_t  st
);
  always_comb begin
    st = '0;
    st.bankAddr = 1'b1;
    unique case (mode)
      M_LIT:      begin st.useLit = 1'b1; st.err = reqCtrl; end
      M_DREG:     begin st.sizeMask = 1'b1; st.bankAddr = 1'b0; st.err = reqCtrl; end
      M_AREG:     begin st.sizeMask = 1'b1; st.err = reqCtrl; end
      M_IND:      begin st.selBase = 1'b1; st.isAddr = 1'b1; end
      M_POSTSTEP: begin st.selBase = 1'b1; st.isAddr = 1'b1; st.postStep = 1'b1; st.err = reqCtrl; end
      M_PRESTEP:  begin st.selBase = 1'b1; st.isAddr = 1'b1; st.preStep = 1'b1; st.err = reqCtrl; end
      M_DISP:     begin st.selBase = 1'b1; st.addDisp = 1'b1; st.isAddr = 1'b1; end
      M_IDX:      begin st.selBase = 1'b1; st.addDisp = 1'b1; st.addIdx = 1'b1; st.isAddr = 1'b1; end
      M_ABS:      begin st.dispFull = 1'b1; st.isAddr = 1'b1; end
      M_PCDISP:   begin st.selPc = 1'b1; st.addDisp = 1'b1; st.isAddr = 1'b1; end
      M_PCIDX:    begin st.selPc = 1'b1; st.addDisp = 1'b1; st.addIdx = 1'b1; st.isAddr = 1'b1; end
      default:    st.err = 1'b1;
    endcase
    if (st.err) begin
      st.postStep = 1'b0;
      st.preStep  = 1'b0;
      st.isAddr   = 1'b0;
    end
  end
endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  eaStrobe_t         st,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] disp,
  input  logic              idxLong,
  input  logic [REG_W-1:0]  baseReg,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] rfBaseData,
  input  logic [DATA_W-1:0] rfIdxData,
  output logic              rspValid,
  output logic              rspIsAddr,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [DATA_W-1:0] wbData
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] step, dispExt, idxVal, baseTerm, dispTerm, idxTerm;
  logic [DATA_W-1:0] sumAddr, stepped, masked, result;

  always_comb begin
    unique case (opSize)
      2'd0:    step = DATA_W'(1);
      2'd1:    step = DATA_W'(2);
      default: step = DATA_W'(4);
    endcase
    dispExt  = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp[DISP_W-1:0]};
    idxVal   = idxLong ? rfIdxData : {{(DATA_W-HALF_W){rfIdxData[HALF_W-1]}}, rfIdxData[HALF_W-1:0]};
    baseTerm = st.selPc ? pc : (st.selBase ? rfBaseData : '0);
    dispTerm = st.dispFull ? disp : (st.addDisp ? dispExt : '0);
    idxTerm  = st.addIdx ? idxVal : '0;
    sumAddr  = baseTerm + dispTerm + idxTerm;
    stepped  = st.preStep ? rfBaseData - step : rfBaseData + step;
    unique case (opSize)
      2'd0:    masked = {{(DATA_W-8){1'b0}}, rfBaseData[7:0]};
      2'd1:    masked = {{(DATA_W-HALF_W){1'b0}}, rfBaseData[HALF_W-1:0]};
      default: masked = rfBaseData;
    endcase
    if (st.err)           result = '0;
    else if (st.useLit)   result = disp;
    else if (st.sizeMask) result = masked;
    else if (st.preStep)  result = stepped;
    else                  result = sumAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspIsAddr <= 1'b0;
      rspErr    <= 1'b0;
      rspData   <= '0;
      wbValid   <= 1'b0;
      wbReg     <= '0;
      wbData    <= '0;
    end else begin
      rspValid <= reqValid;
      wbValid  <= reqValid && (st.postStep || st.preStep);
      if (reqValid) begin
        rspIsAddr <= st.isAddr;
        rspErr    <= st.err;
        rspData   <= result;
        wbReg     <= baseReg;
        wbData    <= (st.postStep || st.preStep) ? stepped : '0;
      end
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqCtrl,
  input  logic [3:0]  mode,
  input  logic [2:0]  baseReg,
  input  logic        idxIsAddr,
  input  logic [2:0]  idxReg,
  input  logic        idxLong,
  input  logic [31:0] disp,
  input  logic [1:0]  opSize,
  input  logic [31:0] pc,
  output logic [3:0]  rfBaseSel,
  input  logic [31:0] rfBaseData,
  output logic [3:0]  rfIdxSel,
  input  logic [31:0] rfIdxData,
  output logic        rspValid,
  output logic        rspIsAddr,
  output logic        rspErr,
  output logic [31:0] rspData,
  output logic        wbValid,
  output logic [2:0]  wbReg,
  output logic [31:0] wbData
);
  eaStrobe_t st;

  ea_ctrl u_ctrl (.mode(mode), .reqCtrl(reqCtrl), .st(st));

  assign rfBaseSel = {st.bankAddr, baseReg};
  assign rfIdxSel  = {idxIsAddr, idxReg};

  ea_dpath #(.DATA_W(32), .DISP_W(16), .REG_W(3)) u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .st(st), .opSize(opSize),
    .disp(disp), .idxLong(idxLong), .baseReg(baseReg), .pc(pc),
    .rfBaseData(rfBaseData), .rfIdxData(rfIdxData),
    .rspValid(rspValid), .rspIsAddr(rspIsAddr), .rspErr(rspErr), .rspData(rspData),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData)
  );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqCtrl,
  input logic [3:0]  mode,
  input logic        rspValid,
  input logic        rspIsAddr,
  input logic        rspErr,
  input logic [31:0] rspData,
  input logic        wbValid,
  input logic [31:0] wbData
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_lit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCtrl && mode == M_LIT) |=> (!rspIsAddr && !wbValid && !rspErr));
  p_wb_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (rspValid && rspIsAddr && !rspErr));
  p_wb_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ((wbData == rspData) || (wbData - rspData == 32'd1) ||
                 (wbData - rspData == 32'd2) || (wbData - rspData == 32'd4)));
  p_ctrl_bad_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCtrl && (mode <= M_AREG || mode == M_POSTSTEP || mode == M_PRESTEP))
      |=> (rspErr && !wbValid));
  p_err_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspData == 32'd0 && !rspIsAddr && !wbValid));
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCtrl(reqCtrl), .mode(mode),
  .rspValid(rspValid), .rspIsAddr(rspIsAddr), .rspErr(rspErr), .rspData(rspData),
  .wbValid(wbValid), .wbData(wbData)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqCtrl, idxIsAddr, idxLong;
  logic [3:0]  mode;
  logic [2:0]  baseReg, idxReg;
  logic [31:0] disp, pc;
  logic [1:0]  opSize;
  logic [3:0]  rfBaseSel, rfIdxSel;
  logic [31:0] rfBaseData, rfIdxData;
  logic        rspValid, rspIsAddr, rspErr, wbValid;
  logic [31:0] rspData, wbData;
  logic [2:0]  wbReg;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] dRegs [8];
  logic [31:0] aRegs [8];

  always #2 clk = ~clk;

  // register file model: {bank, number}, bank 1 = address
  always_comb begin
    rfBaseData = rfBaseSel[3] ? aRegs[rfBaseSel[2:0]] : dRegs[rfBaseSel[2:0]];
    rfIdxData  = rfIdxSel[3]  ? aRegs[rfIdxSel[2:0]]  : dRegs[rfIdxSel[2:0]];
  end

  ea_unit u_ea_unit (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        ctrl;
    logic [3:0]  md;
    logic [2:0]  base;
    logic        idxA;
    logic [2:0]  idx;
    logic        idxL;
    logic [31:0] dsp;
    logic [1:0]  sz;
    logic [31:0] eData;
    logic        eAddr;
    logic        eErr;
    logic        eWb;
    logic [31:0] eWbD;
  } vec_t;

  localparam int NV = 26;
  // d0=12345678 d1=0000FFFE d2=00000010; a0=1000 a1=FFFFFFFE a2=2000 a3=3; pc=4000
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0, 4'd0,  3'd0, 1'b0, 3'd0, 1'b0, 32'hDEADBEEF, 2'd2, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 32'h0},     // R2
    '{4'd3,  1'b0, 4'd1,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd0, 32'h00000078, 1'b0, 1'b0, 1'b0, 32'h0},     // R3
    '{4'd3,  1'b0, 4'd1,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd1, 32'h00005678, 1'b0, 1'b0, 1'b0, 32'h0},     // R3
    '{4'd3,  1'b0, 4'd1,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd3, 32'h12345678, 1'b0, 1'b0, 1'b0, 32'h0},     // R3
    '{4'd3,  1'b0, 4'd2,  3'd1, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0, 32'h0},     // R3
    '{4'd4,  1'b0, 4'd3,  3'd2, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h00002000, 1'b1, 1'b0, 1'b0, 32'h0},     // R4
    '{4'd5,  1'b0, 4'd4,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd1, 32'h00001000, 1'b1, 1'b0, 1'b1, 32'h1002},  // R5
    '{4'd5,  1'b0, 4'd4,  3'd3, 1'b0, 3'd0, 1'b0, 32'h0,        2'd0, 32'h00000003, 1'b1, 1'b0, 1'b1, 32'h4},     // R5
    '{4'd5,  1'b0, 4'd4,  3'd2, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h00002000, 1'b1, 1'b0, 1'b1, 32'h2004},  // R5
    '{4'd6,  1'b0, 4'd5,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h00000FFC, 1'b1, 1'b0, 1'b1, 32'h0FFC},  // R6
    '{4'd6,  1'b0, 4'd5,  3'd3, 1'b0, 3'd0, 1'b0, 32'h0,        2'd0, 32'h00000002, 1'b1, 1'b0, 1'b1, 32'h2},     // R6
    '{4'd6,  1'b0, 4'd5,  3'd2, 1'b0, 3'd0, 1'b0, 32'h0,        2'd1, 32'h00001FFE, 1'b1, 1'b0, 1'b1, 32'h1FFE},  // R6
    '{4'd7,  1'b0, 4'd6,  3'd2, 1'b0, 3'd0, 1'b0, 32'h0000FFF0, 2'd2, 32'h00001FF0, 1'b1, 1'b0, 1'b0, 32'h0},     // R7
    '{4'd7,  1'b0, 4'd6,  3'd1, 1'b0, 3'd0, 1'b0, 32'h00000004, 2'd2, 32'h00000002, 1'b1, 1'b0, 1'b0, 32'h0},     // R7 wrap
    '{4'd8,  1'b0, 4'd7,  3'd2, 1'b0, 3'd1, 1'b0, 32'h00000008, 2'd2, 32'h00002006, 1'b1, 1'b0, 1'b0, 32'h0},     // R8 word
    '{4'd8,  1'b0, 4'd7,  3'd2, 1'b0, 3'd1, 1'b1, 32'h00000008, 2'd2, 32'h00012006, 1'b1, 1'b0, 1'b0, 32'h0},     // R8 long
    '{4'd8,  1'b0, 4'd7,  3'd0, 1'b1, 3'd2, 1'b1, 32'h0,        2'd2, 32'h00003000, 1'b1, 1'b0, 1'b0, 32'h0},     // R8 bank
    '{4'd9,  1'b0, 4'd8,  3'd0, 1'b0, 3'd0, 1'b0, 32'h00FF0000, 2'd2, 32'h00FF0000, 1'b1, 1'b0, 1'b0, 32'h0},     // R9
    '{4'd10, 1'b0, 4'd9,  3'd0, 1'b0, 3'd0, 1'b0, 32'hABCDFFFC, 2'd2, 32'h00003FFC, 1'b1, 1'b0, 1'b0, 32'h0},     // R10
    '{4'd10, 1'b0, 4'd10, 3'd0, 1'b0, 3'd2, 1'b1, 32'h00000002, 2'd2, 32'h00004012, 1'b1, 1'b0, 1'b0, 32'h0},     // R10
    '{4'd11, 1'b1, 4'd3,  3'd2, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h00002000, 1'b1, 1'b0, 1'b0, 32'h0},     // R11
    '{4'd11, 1'b1, 4'd9,  3'd0, 1'b0, 3'd0, 1'b0, 32'h00000010, 2'd2, 32'h00004010, 1'b1, 1'b0, 1'b0, 32'h0},     // R11
    '{4'd11, 1'b1, 4'd4,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0},     // R11
    '{4'd11, 1'b1, 4'd5,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0},     // R11
    '{4'd11, 1'b1, 4'd1,  3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0},     // R11
    '{4'd12, 1'b0, 4'd12, 3'd0, 1'b0, 3'd0, 1'b0, 32'h0,        2'd2, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0}      // R12
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0; reqCtrl = 1'b0; mode = 4'd0; baseReg = 3'd0;
    idxIsAddr = 1'b0; idxReg = 3'd0; idxLong = 1'b0; disp = 32'h0; opSize = 2'd2;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin dRegs[i] = 32'h0; aRegs[i] = 32'h0; end
    dRegs[0] = 32'h12345678; dRegs[1] = 32'h0000FFFE; dRegs[2] = 32'h00000010;
    aRegs[0] = 32'h00001000; aRegs[1] = 32'hFFFFFFFE; aRegs[2] = 32'h00002000; aRegs[3] = 32'h00000003;
    pc = 32'h00004000;
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "reset rspValid", {31'h0, rspValid}, 32'h0);
    check(1, "reset rspData", rspData, 32'h0);
    check(1, "reset wbValid", {31'h0, wbValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "idle rspValid", {31'h0, rspValid}, 32'h0);

    // vector table, back to back
    for (int v = 0; v < NV; v++) begin
      reqValid = 1'b1; reqCtrl = VECS[v].ctrl; mode = VECS[v].md; baseReg = VECS[v].base;
      idxIsAddr = VECS[v].idxA; idxReg = VECS[v].idx; idxLong = VECS[v].idxL;
      disp = VECS[v].dsp; opSize = VECS[v].sz;
      @(negedge clk);
      check(int'(VECS[v].req), "rspValid", {31'h0, rspValid}, 32'h1);
      check(int'(VECS[v].req), "rspData", rspData, VECS[v].eData);
      check(int'(VECS[v].req), "rspIsAddr", {31'h0, rspIsAddr}, {31'h0, VECS[v].eAddr});
      check(int'(VECS[v].req), "rspErr", {31'h0, rspErr}, {31'h0, VECS[v].eErr});
      check(int'(VECS[v].req), "wbValid", {31'h0, wbValid}, {31'h0, VECS[v].eWb});
      if (VECS[v].eWb) begin
        check(int'(VECS[v].req), "wbData", wbData, VECS[v].eWbD);
        check(int'(VECS[v].req), "wbReg", {29'h0, wbReg}, {29'h0, VECS[v].base});
      end
    end

    // R1: gap after the stream drops valid and write-back
    idle();
    @(negedge clk);
    check(1, "gap rspValid", {31'h0, rspValid}, 32'h0);
    check(5, "gap wbValid", {31'h0, wbValid}, 32'h0);

    // R3/R8 read selects are combinational from the specifier
    mode = 4'd1; baseReg = 3'd5; idxIsAddr = 1'b1; idxReg = 3'd6;
    #1;
    check(3, "rfBaseSel data bank", {28'h0, rfBaseSel}, 32'h5);
    check(8, "rfIdxSel address bank", {28'h0, rfIdxSel}, 32'hE);
    mode = 4'd7; baseReg = 3'd7;
    #1;
    check(8, "rfBaseSel address bank", {28'h0, rfBaseSel}, 32'hF);
    idle();

    // R12: undefined code on a control request
    reqValid = 1'b1; reqCtrl = 1'b1; mode = 4'd15; baseReg = 3'd0;
    @(negedge clk);
    check(12, "code 15 rspErr", {31'h0, rspErr}, 32'h1);
    check(12, "code 15 wbValid", {31'h0, wbValid}, 32'h0);
    idle();

    // R1: reset mid-stream clears outputs
    reqValid = 1'b1; mode = 4'd4; baseReg = 3'd0; opSize = 2'd0;
    rstN = 1'b0;
    @(negedge clk);
    check(1, "reset wins rspValid", {31'h0, rspValid}, 32'h0);
    check(1, "reset wins wbValid", {31'h0, wbValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(5, "post-reset step byte wbData", wbData, 32'h00001001);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule